// File: doc/BRIEF.md
# UART Receive Software Flow-Control Detector

This block watches the receive side of one UART channel. Each time the deserializer hands over a completed character, the block compares it against four programmable control bytes. These are two "resume" bytes (`xon_a`, `xon_b`) and two "pause" bytes (`xoff_a`, `xoff_b`). Depending on the selected mode, it treats one byte or a back-to-back pair of bytes as a flow-control command.

A pause command raises the transmit-halt output and a resume command drops it. Characters used up as commands are withheld from the receive FIFO. All other characters are forwarded with a one-cycle push strobe.

An optional special-character detector compares every byte with `xoff_b`. It raises a sticky interrupt flag on a match. When it is combined with the mode that uses `xon_b`/`xoff_b`, a matching byte is dropped from the FIFO and raises both the pause and the special-character interrupts.

All outputs are registered. A byte presented with `rx_valid` high on clock edge N shows its effect on the outputs from edge N onward, so it is visible during the following cycle.

Top module: `uart_rx_swfc`

## Requirements
- R1: With `rst` high at a clock edge, `tx_halt`, `push`, `xoff_irq` and `spec_irq` are 0 after that edge, whatever the other inputs are.
- R2: With `fc_sel` = 2'b10 (single mode, set A), a byte equal to `xoff_a` sets `tx_halt` and a byte equal to `xon_a` clears it. Neither byte is pushed. Bytes equal to `xon_b` or `xoff_b` are pushed.
- R3: With `fc_sel` = 2'b01 (single mode, set B), a byte equal to `xoff_b` sets `tx_halt` and a byte equal to `xon_b` clears it. Neither byte is pushed. Bytes equal to `xon_a` or `xoff_a` are pushed.
- R4: With `fc_sel` = 2'b00, every valid byte is pushed and `tx_halt` keeps its value.
- R5: With `fc_sel` = 2'b11 (pair mode), `xoff_a` immediately followed by `xoff_b` sets `tx_halt`, and `xon_a` immediately followed by `xon_b` clears it. The first byte of a pair is pushed and the completing second byte is not.
- R6: In pair mode, a byte that does not complete a pending pair cancels it. That byte is then evaluated as a possible first byte of a new pair, and a lone second byte is pushed as data.
- R7: `push` is high for exactly one cycle after each byte accepted with `rx_valid` and not consumed. `push_data` then equals that byte, with `push_data[0]` = `rx_byte[0]`.
- R8: `xoff_irq` is set by every completed pause command in any mode.
- R9: With `spec_en` = 1 and any `fc_sel` other than 2'b01, a byte equal to `xoff_b` sets `spec_irq` and is still pushed, unless the mode consumes it. In that case `xoff_irq` is untouched.
- R10: With `spec_en` = 1 and `fc_sel` = 2'b01, a byte equal to `xoff_b` is not pushed. It sets `tx_halt`, `xoff_irq` and `spec_irq`.
- R11: With `spec_en` = 0, no byte sets `spec_irq`.
- R12: A flag stays set until its clear input (`xoff_irq_clr` or `spec_irq_clr`) is high at an edge. If a new set event arrives on the same edge as the clear, the flag ends up set.
- R13: While `rx_valid` is low, `rx_byte` is ignored: `push` stays 0 and `tx_halt` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a new character |
| fc_sel | input | 2 | 00 off, 10 single set A, 01 single set B, 11 pair A-then-B |
| spec_en | input | 1 | Enable special-character compare against `xoff_b` |
| xon_a | input | 8 | Resume byte, set A / first of pair |
| xon_b | input | 8 | Resume byte, set B / second of pair |
| xoff_a | input | 8 | Pause byte, set A / first of pair |
| xoff_b | input | 8 | Pause byte, set B / second of pair; special character |
| xoff_irq_clr | input | 1 | Clear strobe for `xoff_irq` |
| spec_irq_clr | input | 1 | Clear strobe for `spec_irq` |
| tx_halt | output | 1 | Transmitter must pause |
| push | output | 1 | Write strobe toward the receive FIFO |
| push_data | output | 8 | Byte to write |
| xoff_irq | output | 1 | Sticky: pause command received |
| spec_irq | output | 1 | Sticky: special character received |

## Verification
The bench targets the mode cross-terms. One case is `xoff_b` arriving under set A, which must pass through as data; a design that decodes both sets at once would halt the transmitter instead. Another is the same byte under set B with the special detector on; a design that still pushed it would corrupt the FIFO stream. The pair tests interleave broken pairs whose breaking byte starts a new pair. A design that dropped back to idle without re-evaluating would miss the following resume and leave `tx_halt` stuck high. The last cases are a set and a clear arriving on the same edge, and a pause byte held on `rx_byte` with `rx_valid` low. A wrong priority would lose the interrupt, and a missing qualifier would raise a phantom halt.

// File: rtl/uart_swfc_pkg.sv
package uart_swfc_pkg;

  // receive flow-control selection, encoding fixed by R2..R5
  typedef enum logic [1:0] {
    FC_OFF  = 2'b00,
    FC_SETB = 2'b01,
    FC_SETA = 2'b10,
    FC_PAIR = 2'b11
  } fc_mode_t;

  // pair-mode progress
  typedef enum logic [1:0] {
    PD_NONE = 2'b00,
    PD_ON   = 2'b01,
    PD_OFF  = 2'b10
  } pend_t;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_XOFF = 0;
  localparam int unsigned FLAG_SPEC = 1;

endpackage

// File: rtl/swfc_match.sv
module swfc_match
  import uart_swfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] byte_i,
  input  fc_mode_t     mode_i,
  input  pend_t        pend_i,
  input  logic         spec_en_i,
  input  logic [W-1:0] xon_a_i,
  input  logic [W-1:0] xon_b_i,
  input  logic [W-1:0] xoff_a_i,
  input  logic [W-1:0] xoff_b_i,
  output logic         on_done_o,
  output logic         off_done_o,
  output logic         consume_o,
  output logic         spec_hit_o,
  output pend_t        pend_nx_o
);

  logic eq_on_a, eq_on_b, eq_off_a, eq_off_b;

  always_comb begin
    eq_on_a  = (byte_i == xon_a_i);
    eq_on_b  = (byte_i == xon_b_i);
    eq_off_a = (byte_i == xoff_a_i);
    eq_off_b = (byte_i == xoff_b_i);
  end

  always_comb begin
    on_done_o  = 1'b0;
    off_done_o = 1'b0;
    pend_nx_o  = PD_NONE;
    spec_hit_o = spec_en_i && eq_off_b;
    unique case (mode_i)
      FC_SETA: begin
        off_done_o = eq_off_a;
        on_done_o  = eq_on_a && !eq_off_a;
      end
      FC_SETB: begin
        off_done_o = eq_off_b;
        on_done_o  = eq_on_b && !eq_off_b;
      end
      FC_PAIR: begin
        if (pend_i == PD_OFF && eq_off_b) begin
          off_done_o = 1'b1;
        end else if (pend_i == PD_ON && eq_on_b) begin
          on_done_o = 1'b1;
        end else if (eq_off_a) begin
          pend_nx_o = PD_OFF;
        end else if (eq_on_a) begin
          pend_nx_o = PD_ON;
        end
      end
      default: ;
    endcase
    consume_o = on_done_o || off_done_o;
  end

endmodule

// File: rtl/swfc_track.sv
module swfc_track
  import uart_swfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [W-1:0] byte_i,
  input  fc_mode_t     mode_i,
  input  logic         on_done_i,
  input  logic         off_done_i,
  input  logic         consume_i,
  input  pend_t        pend_nx_i,
  output pend_t        pend_o,
  output logic         halt_o,
  output logic         push_o,
  output logic [W-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= PD_NONE;
      halt_o <= 1'b0;
      push_o <= 1'b0;
      data_o <= '0;
    end else begin
      push_o <= valid_i && !consume_i;
      if (valid_i) data_o <= byte_i;
      if (mode_i != FC_PAIR) pend_o <= PD_NONE;
      else if (valid_i)      pend_o <= pend_nx_i;
      if (valid_i && off_done_i)     halt_o <= 1'b1;
      else if (valid_i && on_done_i) halt_o <= 1'b0;
    end
  end

  // R13: halt only moves on an accepted byte
  a_r13_halt_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(halt_o));
  // R2: a completed pause command always leaves halt set
  a_r2_halt_set: assert property (@(posedge clk) disable iff (rst)
    (valid_i && off_done_i) |=> halt_o);
  // R5: no pair progress is kept outside pair mode
  a_r5_pend_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_i != FC_PAIR) |=> (pend_o == PD_NONE));
  // R7: a push always follows an accepted byte and carries it
  a_r7_push_src: assert property (@(posedge clk) disable iff (rst)
    push_o |-> ($past(valid_i) && data_o == $past(byte_i)));

endmodule

// File: rtl/swfc_flag.sv
module swfc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R12: set wins over a simultaneous clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  a_r12_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && flag_o) |=> flag_o);

endmodule

// File: rtl/uart_rx_swfc.sv
module uart_rx_swfc
  import uart_swfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_valid,
  input  logic [1:0]   fc_sel,
  input  logic         spec_en,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic         xoff_irq_clr,
  input  logic         spec_irq_clr,
  output logic         tx_halt,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic         xoff_irq,
  output logic         spec_irq
);

  fc_mode_t mode;
  pend_t    pend, pend_nx;
  logic     on_done, off_done, consume, spec_hit;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  assign mode = fc_mode_t'(fc_sel);

  swfc_match #(.W(W)) u_match (
    .byte_i    (rx_byte),
    .mode_i    (mode),
    .pend_i    (pend),
    .spec_en_i (spec_en),
    .xon_a_i   (xon_a),
    .xon_b_i   (xon_b),
    .xoff_a_i  (xoff_a),
    .xoff_b_i  (xoff_b),
    .on_done_o (on_done),
    .off_done_o(off_done),
    .consume_o (consume),
    .spec_hit_o(spec_hit),
    .pend_nx_o (pend_nx)
  );

  swfc_track #(.W(W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (rx_valid),
    .byte_i    (rx_byte),
    .mode_i    (mode),
    .on_done_i (on_done),
    .off_done_i(off_done),
    .consume_i (consume),
    .pend_nx_i (pend_nx),
    .pend_o    (pend),
    .halt_o    (tx_halt),
    .push_o    (push),
    .data_o    (push_data)
  );

  assign flag_set[FLAG_XOFF] = rx_valid && off_done;
  assign flag_set[FLAG_SPEC] = rx_valid && spec_hit;
  assign flag_clr[FLAG_XOFF] = xoff_irq_clr;
  assign flag_clr[FLAG_SPEC] = spec_irq_clr;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    swfc_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .flag_o(flag_q[g])
    );
  end

  assign xoff_irq = flag_q[FLAG_XOFF];
  assign spec_irq = flag_q[FLAG_SPEC];

  // R10: special byte under set B is dropped and raises both flags
  a_r10_spec_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && spec_en && fc_sel == 2'b01 && rx_byte == xoff_b)
    |=> (!push && xoff_irq && spec_irq && tx_halt));
  // R11: the special flag cannot rise while the detector is off
  a_r11_spec_off: assert property (@(posedge clk) disable iff (rst)
    (!spec_en && !spec_irq) |=> !spec_irq);
  // R4: with flow control off every accepted byte is pushed
  a_r4_pass_all: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fc_sel == 2'b00) |=> push);

endmodule

// File: tb/sim_uart_rx_swfc.sv
module sim_uart_rx_swfc;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 24;

  typedef struct packed {
    logic [1:0] sel;
    logic       spec;
    logic [7:0] data;
    logic       e_push;
    logic       e_halt;
    logic       e_xirq;
    logic       e_sirq;
  } vec_t;

  // control bytes: xon_a=11 xoff_a=13 xon_b=91 xoff_b=93, plain data 41
  localparam vec_t TBL [NV] = '{
    '{2'b10, 1'b0, 8'h41, 1'b1, 1'b0, 1'b0, 1'b0}, // 0  R2 data
    '{2'b10, 1'b0, 8'h13, 1'b0, 1'b1, 1'b1, 1'b0}, // 1  R2 R8 pause
    '{2'b10, 1'b0, 8'h93, 1'b1, 1'b1, 1'b0, 1'b0}, // 2  R2 set B byte passes
    '{2'b10, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0}, // 3  R2 resume
    '{2'b01, 1'b0, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0}, // 4  R3
    '{2'b01, 1'b0, 8'h93, 1'b0, 1'b1, 1'b1, 1'b0}, // 5  R3
    '{2'b01, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0}, // 6  R3
    '{2'b01, 1'b0, 8'h91, 1'b0, 1'b0, 1'b0, 1'b0}, // 7  R3
    '{2'b00, 1'b0, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0}, // 8  R4
    '{2'b00, 1'b0, 8'h93, 1'b1, 1'b0, 1'b0, 1'b0}, // 9  R4
    '{2'b10, 1'b1, 8'h93, 1'b1, 1'b0, 1'b0, 1'b1}, // 10 R9
    '{2'b01, 1'b1, 8'h93, 1'b0, 1'b1, 1'b1, 1'b1}, // 11 R10
    '{2'b10, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0}, // 12 R2
    '{2'b10, 1'b0, 8'h93, 1'b1, 1'b0, 1'b0, 1'b0}, // 13 R11
    '{2'b11, 1'b0, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0}, // 14 R5 first pushed
    '{2'b11, 1'b0, 8'h93, 1'b0, 1'b1, 1'b1, 1'b0}, // 15 R5 pair pause
    '{2'b11, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0}, // 16 R6 pending resume
    '{2'b11, 1'b0, 8'h13, 1'b1, 1'b1, 1'b0, 1'b0}, // 17 R6 breaks, restarts
    '{2'b11, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0}, // 18 R6 breaks, restarts
    '{2'b11, 1'b0, 8'h91, 1'b0, 1'b0, 1'b0, 1'b0}, // 19 R6 completes resume
    '{2'b11, 1'b0, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0}, // 20 R6
    '{2'b11, 1'b0, 8'h41, 1'b1, 1'b0, 1'b0, 1'b0}, // 21 R6 cancel
    '{2'b11, 1'b0, 8'h93, 1'b1, 1'b0, 1'b0, 1'b0}, // 22 R6 lone second pushed
    '{2'b11, 1'b1, 8'h93, 1'b1, 1'b0, 1'b0, 1'b1}  // 23 R9 pair mode
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic [1:0] fc_sel;
  logic       spec_en;
  logic       xoff_irq_clr, spec_irq_clr;
  logic       tx_halt, push, xoff_irq, spec_irq;
  logic [7:0] push_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_swfc #(.W(8)) u0 (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .fc_sel(fc_sel), .spec_en(spec_en),
    .xon_a(8'h11), .xon_b(8'h91), .xoff_a(8'h13), .xoff_b(8'h93),
    .xoff_irq_clr(xoff_irq_clr), .spec_irq_clr(spec_irq_clr),
    .tx_halt(tx_halt), .push(push), .push_data(push_data),
    .xoff_irq(xoff_irq), .spec_irq(spec_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i <= 3 || i == 12) return "R2";
    if (i <= 7)            return "R3";
    if (i <= 9)            return "R4";
    if (i == 10 || i == 23) return "R9";
    if (i == 11)           return "R10";
    if (i == 13)           return "R11";
    if (i <= 15)           return "R5";
    return "R6";
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    xoff_irq_clr = 1'b1;
    spec_irq_clr = 1'b1;
    @(negedge clk);
    xoff_irq_clr = 1'b0;
    spec_irq_clr = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1; rx_valid = 1'b1; rx_byte = 8'h13; fc_sel = 2'b10;
    spec_en = 1'b1; xoff_irq_clr = 1'b0; spec_irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state even with a pause byte held valid
    chk("R1", "halt", {7'd0, tx_halt}, 8'd0);
    chk("R1", "push", {7'd0, push}, 8'd0);
    chk("R1", "irqs", {6'd0, xoff_irq, spec_irq}, 8'd0);
    rx_valid = 1'b0; spec_en = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fc_sel  = TBL[i].sel;
      spec_en = TBL[i].spec;
      clear_flags();
      send(TBL[i].data);
      chk(tag_of(i), $sformatf("vec%0d push", i), {7'd0, push}, {7'd0, TBL[i].e_push});
      if (TBL[i].e_push)
        chk("R7", $sformatf("vec%0d data", i), push_data, TBL[i].data);
      chk(tag_of(i), $sformatf("vec%0d halt", i), {7'd0, tx_halt}, {7'd0, TBL[i].e_halt});
      chk("R8", $sformatf("vec%0d xoff_irq", i), {7'd0, xoff_irq}, {7'd0, TBL[i].e_xirq});
      chk(tag_of(i), $sformatf("vec%0d spec_irq", i), {7'd0, spec_irq}, {7'd0, TBL[i].e_sirq});
    end

    // R7: strobe lasts one cycle, bit order preserved
    fc_sel = 2'b00; spec_en = 1'b0;
    send(8'h01);
    chk("R7", "lsb data", push_data, 8'h01);
    @(negedge clk);
    chk("R7", "push one cycle", {7'd0, push}, 8'd0);

    // R13: pause byte with valid low does nothing
    fc_sel = 2'b10;
    @(negedge clk);
    rx_byte = 8'h13;
    repeat (3) @(negedge clk);
    chk("R13", "halt idle", {7'd0, tx_halt}, 8'd0);
    chk("R13", "push idle", {7'd0, push}, 8'd0);

    // R12: set on the same edge as clear wins, then clear alone drops it
    @(negedge clk);
    rx_byte = 8'h13; rx_valid = 1'b1; xoff_irq_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; xoff_irq_clr = 1'b0;
    chk("R12", "set beats clear", {7'd0, xoff_irq}, 8'd1);
    @(negedge clk);
    chk("R12", "sticky", {7'd0, xoff_irq}, 8'd1);
    xoff_irq_clr = 1'b1;
    @(negedge clk);
    xoff_irq_clr = 1'b0;
    chk("R12", "clear", {7'd0, xoff_irq}, 8'd0);

    // R1: reset mid-run drops a raised halt
    chk("R1", "halt before reset", {7'd0, tx_halt}, 8'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "halt after reset", {7'd0, tx_halt}, 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule